// File: doc/BRIEF.md
# Watchdog Timer with Debug-Halt Output Masking

This block is a memory-mapped watchdog. A 16-bit down-counter is clocked by a two-stage clock divider. The first stage is a programmable prescaler that divides by 1 to 256. The second stage is a fixed-ratio divider that divides by 16, 32, 64 or 128. Each time the counter reaches zero on a divided tick, the watchdog has expired. On expiry it can raise a level interrupt, a one-cycle reset request, or both. It then reloads itself from a software-programmed reload value. Software keeps the system alive by writing the counter directly before it runs out.

A debug-halt acknowledge input from the CPU core can silence both outputs. This happens only while a control bit allows it. The counter keeps running while the outputs are masked. A pending interrupt stays latched, so it shows again once the core leaves debug. Access is through a simple single-cycle register port: a write strobe, a 2-bit word address, write data, and combinational read data.

Top module: `wdog_dbgmask`

## Requirements
- R1: After reset, both outputs are low. The control word (address 0) reads 0. The reload value (address 1) and the counter (address 2) both read 0xFFFF.
- R2: Word addresses are: 0 control, 1 reload value, 2 counter, 3 interrupt clear. Address 3 is write-only and reads 0. The control fields are: bit 0 reset-request enable, bit 2 interrupt enable, bits 4:3 divider code, bit 5 run enable, bits 15:8 prescale value P, bit 16 debug mask. All other control bits read as 0.
- R3: While run enable is set, the counter moves once every (P+1)*D clock cycles. D is 16, 32, 64 or 128 for divider codes 0, 1, 2 and 3. While run enable is clear, the counter holds and both divider stages restart from zero.
- R4: A tick that finds the counter at 0 is an expiry. The counter then takes the reload value, so one expiry follows every reload+1 ticks.
- R5: A write to address 2 loads the counter with the written value in that cycle. It overrides a coincident tick, and no expiry occurs in that cycle.
- R6: An expiry with interrupt enable set makes the interrupt output high from the next cycle on. It stays high until address 3 is written. An expiry in the same cycle as a clear leaves the interrupt pending.
- R7: An expiry with reset-request enable set produces a reset-request pulse that is exactly one clock cycle long, in the cycle after the expiry.
- R8: While the debug mask bit and the debug-halt acknowledge input are both high, both outputs are low. During that time the counter keeps running and a pending interrupt stays latched. The interrupt output reappears at once when the acknowledge input falls.
- R9: An expiry with interrupt enable clear raises no interrupt. An expiry with reset-request enable clear raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dbg_halt_ack | input | 1 | CPU debug-halt acknowledge |
| wd_irq | output | 1 | Watchdog interrupt request (level) |
| wd_rst_req | output | 1 | Watchdog reset request (one-cycle pulse) |

## Verification
The bench builds the block with its default 16-bit counter. It programs small reload and counter values, so that many expiries fall inside a short run at the fastest divider setting. It also runs one case with a larger prescale value and divider code 3, which exercises the longest tick period on a handful of ticks. The same short reloads bring keepalive rewrites, masked expiries and the interrupt-clear interplay within reach of a cycle-exact reference comparison.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W  = 32;
  localparam int PRE_W   = 8;
  localparam int DIVC_W  = 2;
  localparam int DIVCNT_W = 7;

  localparam int B_RST_EN   = 0;
  localparam int B_IRQ_EN   = 2;
  localparam int B_DIV_LO   = 3;
  localparam int B_RUN      = 5;
  localparam int B_PRE_LO   = 8;
  localparam int B_DBG_MASK = 16;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_RELOAD = 2'd1,
    A_COUNT  = 2'd2,
    A_ICLR   = 2'd3
  } wd_addr_e;

  typedef struct packed {
    logic              dbg_mask;
    logic [PRE_W-1:0]  presc;
    logic              run;
    logic [DIVC_W-1:0] div_code;
    logic              irq_en;
    logic              rst_en;
  } wd_ctl_t;

  // Control word -> fields
  function automatic wd_ctl_t ctl_from_word(input logic [DATA_W-1:0] w);
    wd_ctl_t c;
    c.rst_en   = w[B_RST_EN];
    c.irq_en   = w[B_IRQ_EN];
    c.div_code = w[B_DIV_LO +: DIVC_W];
    c.run      = w[B_RUN];
    c.presc    = w[B_PRE_LO +: PRE_W];
    c.dbg_mask = w[B_DBG_MASK];
    return c;
  endfunction

  // Fields -> control word, unused bits zero
  function automatic logic [DATA_W-1:0] ctl_to_word(input wd_ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_RST_EN]             = c.rst_en;
    w[B_IRQ_EN]             = c.irq_en;
    w[B_DIV_LO +: DIVC_W]   = c.div_code;
    w[B_RUN]                = c.run;
    w[B_PRE_LO +: PRE_W]    = c.presc;
    w[B_DBG_MASK]           = c.dbg_mask;
    return w;
  endfunction

  // Last state of the fixed divider: 16<<code minus one
  function automatic logic [DIVCNT_W-1:0] div_last(input logic [DIVC_W-1:0] code);
    logic [DIVCNT_W:0] len;
    len = (DIVCNT_W+1)'(16) << code;
    return DIVCNT_W'(len - 1'b1);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output wd_ctl_t           ctl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic              irq_clr
);

  wd_addr_e a;
  assign a = wd_addr_e'(addr);

  assign cnt_load = wr && (a == A_COUNT);
  assign irq_clr  = wr && (a == A_ICLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      reload <= '1;
    end else if (wr) begin
      if (a == A_CTRL)   ctl    <= ctl_from_word(wdata);
      if (a == A_RELOAD) reload <= wdata[CNT_W-1:0];
    end
  end

  // R2: a control write stores exactly the defined fields
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && a == A_CTRL) |=> (ctl_to_word(ctl) == ($past(wdata) & ctl_to_word('1))));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  presc,
  input  logic [DIVC_W-1:0] div_code,
  output logic              tick
);

  logic [PRE_W-1:0]    pre_q;
  logic [DIVCNT_W-1:0] div_q;
  logic                pre_wrap;
  logic                div_wrap;

  assign pre_wrap = (pre_q == presc);
  assign div_wrap = (div_q == div_last(div_code));
  assign tick     = run && pre_wrap && div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      div_q <= div_wrap ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R3: ticks are at least 16 cycles apart
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3: stopped divider restarts from zero
  p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && div_q == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign expire = tick && !load && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '1;
    else if (load)  count <= load_val;
    else if (tick)  count <= next_count(count, reload);
  end

  // R4: expiry reloads
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(reload)));

  // R5: keepalive write wins
  p_keepalive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  // R3: no tick, no load -> counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

endmodule

// File: rtl/wdog_dbgmask.sv
module wdog_dbgmask
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dbg_halt_ack,
  output logic              wd_irq,
  output logic              wd_rst_req
);

  wd_ctl_t          ctl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             cnt_load;
  logic             irq_clr;
  logic             tick;
  logic             expire;
  logic             irq_set;
  logic             rst_set;
  logic             irq_pend_q;
  logic             rst_pulse_q;
  logic             out_gate;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctl(ctl), .reload(reload), .cnt_load(cnt_load), .irq_clr(irq_clr)
  );

  wdog_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .presc(ctl.presc),
    .div_code(ctl.div_code), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(reg_wdata[CNT_W-1:0]), .reload(reload),
    .count(count), .expire(expire)
  );

  assign irq_set  = expire && ctl.irq_en;
  assign rst_set  = expire && ctl.rst_en;
  assign out_gate = ctl.dbg_mask && dbg_halt_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend_q  <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= rst_set;
      if (irq_set)      irq_pend_q <= 1'b1;
      else if (irq_clr) irq_pend_q <= 1'b0;
    end
  end

  assign wd_irq     = irq_pend_q  && !out_gate;
  assign wd_rst_req = rst_pulse_q && !out_gate;

  always_comb begin
    unique case (wd_addr_e'(reg_addr))
      A_CTRL:   reg_rdata = ctl_to_word(ctl);
      A_RELOAD: reg_rdata = DATA_W'(reload);
      A_COUNT:  reg_rdata = DATA_W'(count);
      default:  reg_rdata = '0;
    endcase
  end

  // R6: pending interrupt survives until cleared
  p_irq_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_q && !irq_clr) |=> irq_pend_q);

  // R6: set wins over clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_pend_q);

  // R7: reset request lasts one cycle
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);

  // R8: masked debug halt silences both outputs
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.dbg_mask && dbg_halt_ack) |-> (!wd_irq && !wd_rst_req));

  // R9: no interrupt without enable
  p_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pend_q && !(expire && ctl.irq_en)) |=> !irq_pend_q);

endmodule

// File: tb/tb_wdog_dbgmask.sv
module tb_wdog_dbgmask;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_halt_ack = 1'b0;
  logic        wd_irq;
  logic        wd_rst_req;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  wdog_dbgmask dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt_ack(dbg_halt_ack),
    .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
  );

  // Behavioural reference
  int m_ctl, m_rld, m_cnt, m_ph;
  bit m_pend, m_rstp;
  int rst_seen, irq_high;

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_rld = 'hFFFF; m_cnt = 'hFFFF; m_ph = 0; m_pend = 0; m_rstp = 0;
    end else begin
      int period;
      bit tk, ex, ld;
      period = (((m_ctl >> 8) & 255) + 1) * (16 << ((m_ctl >> 3) & 3));
      tk = 0;
      if (m_ctl[5]) begin
        tk = (m_ph == period - 1);
        m_ph = tk ? 0 : m_ph + 1;
      end else m_ph = 0;
      ld = reg_wr && reg_addr == 2;
      ex = tk && !ld && m_cnt == 0;
      m_rstp = ex && m_ctl[0];
      if (ex && m_ctl[2]) m_pend = 1;
      else if (reg_wr && reg_addr == 3) m_pend = 0;
      if (ld) m_cnt = reg_wdata & 'hFFFF;
      else if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      if (reg_wr && reg_addr == 0) m_ctl = reg_wdata & 'h1FF3D;
      if (reg_wr && reg_addr == 1) m_rld = reg_wdata & 'hFFFF;
    end
    #5;
    begin
      bit gate;
      int exp_rd;
      gate = m_ctl[16] && dbg_halt_ack;
      chk(wd_irq == (m_pend && !gate), "R6 R8 irq", wd_irq, m_pend && !gate);
      chk(wd_rst_req == (m_rstp && !gate), "R7 R8 rst_req", wd_rst_req, m_rstp && !gate);
      case (reg_addr)
        2'd0: exp_rd = m_ctl;
        2'd1: exp_rd = m_rld;
        2'd2: exp_rd = m_cnt;
        default: exp_rd = 0;
      endcase
      chk(reg_rdata == exp_rd, "R2 R3 R4 rdata", reg_rdata, exp_rd);
      if (wd_rst_req) rst_seen++;
      if (wd_irq) irq_high++;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(1, v); chk(v == 'hFFFF, "R1 reload", v, 'hFFFF);
    rd(2, v); chk(v == 'hFFFF, "R1 count", v, 'hFFFF);
    chk(!wd_irq && !wd_rst_req, "R1 outputs", wd_irq, 0);
    // R2 field mask and write-only clear
    wr(0, 'hFFFF_FFFF);
    wr(0, 0);
    wr(0, 'hFFFF_FFDF);
    rd(0, v); chk(v == 'h1FF1D, "R2 ctrl mask", v, 'h1FF1D);
    rd(3, v); chk(v == 0, "R2 iclr reads 0", v, 0);
    wr(0, 0);
    // R3 R4 R6 fast expiry with interrupt
    wr(1, 3); wr(2, 3); wr(0, 'h24);
    idle(200);
    chk(wd_irq == 1, "R6 irq raised", wd_irq, 1);
    wr(3, 0);
    chk(wd_irq == 0, "R6 irq cleared", wd_irq, 1);
    idle(150);
    wr(0, 0); wr(3, 0);
    // R7 reset pulses
    rst_seen = 0;
    wr(1, 1); wr(2, 1); wr(0, 'h21);
    idle(320);
    chk(rst_seen >= 8, "R7 reset pulses seen", rst_seen, 8);
    wr(0, 0);
    // R8 debug masking
    dbg_halt_ack = 1'b1; irq_high = 0; rst_seen = 0;
    wr(1, 2); wr(2, 2); wr(0, 'h10025);
    idle(100);
    rd(2, v); idle(40); rd(2, v2);
    chk(v != v2, "R8 counter runs while masked", v2, v);
    idle(200);
    chk(irq_high == 0 && rst_seen == 0, "R8 outputs silent", irq_high + rst_seen, 0);
    @(negedge clk) dbg_halt_ack = 1'b0;
    #1 chk(wd_irq == 1, "R8 pending irq reappears", wd_irq, 1);
    wr(0, 0); wr(3, 0);
    // R9 no enables
    irq_high = 0; rst_seen = 0;
    wr(1, 1); wr(2, 1); wr(0, 'h20);
    idle(300);
    chk(irq_high == 0 && rst_seen == 0, "R9 no outputs", irq_high + rst_seen, 0);
    wr(0, 0);
    // R5 keepalive
    rst_seen = 0;
    wr(1, 10); wr(2, 10); wr(0, 'h25);
    for (int i = 0; i < 6; i++) begin
      idle(100); wr(2, 10);
    end
    chk(rst_seen == 0 && wd_irq == 0, "R5 keepalive prevents expiry", rst_seen, 0);
    wr(0, 0);
    // R3 other divider codes
    wr(1, 2); wr(2, 2); wr(0, 'h0134);
    idle(700);
    wr(0, 0); wr(3, 0);
    irq_high = 0;
    wr(2, 2); wr(0, 'h023C);
    idle(1300);
    chk(irq_high > 0, "R3 R4 slow divider expiry", irq_high, 1);
    wr(0, 0);
    idle(5);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule